// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-mapped master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). It uses the Clause 22 frame format. Software programs a clock divider and an enable flag. It then posts one read or write command into a single access register. The command word carries a start flag, a direction flag, the PHY address, the PHY register address and sixteen data bits. The block drives a preamble and a frame onto the pins and samples the PHY's reply. When the frame ends it drops the start flag. For reads it also records whether the PHY acknowledged and stores the returned data.

A bypass mode hands the pins to software. In this mode a register bit drives each of MDC, the MDIO output enable and the MDIO output value. The same register reads back the live MDIO input level. The register port is a single-beat valid/ready interface. Reads return data one cycle after they are accepted.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads as zero except the control register, which reads 0x8000_0000 (idle set). MDC and the MDIO output enable are low.
- R2: The control register (word 0) holds the enable flag at bit 30 and the clock divider at bits 15:0, and both read back as written. Bit 31 is a read-only idle flag that is high whenever no frame is on the wire.
- R3: One MDC period lasts divider+1 clock cycles, and a divider of 0 behaves as 1. MDC toggles only while a frame is in progress.
- R4: Writing the access register (word 1) with bit 31 (start) set begins a command. Bit 31 reads 1, and the idle flag reads 0, until the frame has been fully sent. Then bit 31 clears.
- R5: In the access register, bit 30 selects write (1) or read (0), bits 25:21 hold the PHY register address, bits 20:16 the PHY address and bits 15:0 the data. Each frame is sent as follows, MSB first:
  - 32 one bits of preamble
  - start bits 01
  - opcode: 01 for a write, 10 for a read
  - the 5-bit PHY address
  - the 5-bit register address
  - turnaround: 10 on writes
  - 16 data bits
- R6: On a read, the master releases MDIO (output enable low) from the first turnaround bit to the end of the frame. It samples MDIO while MDC rises. Access bit 29 is set only if the PHY drove the second turnaround bit low. In that case bits 15:0 hold the 16 bits the PHY returned.
- R7: A write to the access register while bit 31 is still set has no effect. The stored fields are unchanged and no second frame is sent.
- R8: A command starts only while the enable flag is set and the manual mode is off. Clearing the enable flag during a frame lets that frame finish, after which idle reads 1. A command posted while the block is disabled stays pending with MDC quiet until the enable flag is set.
- R9: Bit 31 of the mode register (word 2) selects manual mode. In manual mode the manual register (word 3) drives MDC from bit 2, the output enable from bit 1 and the MDIO output from bit 0. Reading bit 0 returns the MDIO input level.
- R10: The register port is always ready. A read's data appears on the read data output with the valid flag high for one cycle, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Request accepted (always high) |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| mdc_o | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input level |

## Verification
The bench uses the default parameters: a 16-bit divider, a 32-bit preamble and a 2-bit register address. Software programs divider values of 0, 3 and 4. These small values keep each frame a few hundred cycles long. They also reach the clamp of a zero divider to a two-cycle period, and they give a behavioural PHY half a bit period to drive its reply after each MDC fall. The largest divider values are within the design's range but are not reached by the bench.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W       = 32;
  localparam int PHY_AD_W    = 5;
  localparam int REG_AD_W    = 5;
  localparam int MDATA_W     = 16;

  // word addresses of the register file
  localparam int ADR_CTRL    = 0;
  localparam int ADR_ACCESS  = 1;
  localparam int ADR_MODE    = 2;
  localparam int ADR_MANUAL  = 3;

  // access register fields
  localparam int B_GO        = 31;
  localparam int B_WR        = 30;
  localparam int B_ACK       = 29;
  localparam int B_RAD_LO    = 21;
  localparam int B_PAD_LO    = 16;

  // control register fields
  localparam int B_IDLE      = 31;
  localparam int B_EN        = 30;

  typedef struct packed {
    logic                wr;
    logic [REG_AD_W-1:0] reg_ad;
    logic [PHY_AD_W-1:0] phy_ad;
    logic [MDATA_W-1:0]  data;
  } mdm_cmd_t;
endpackage

// File: rtl/mdm_engine.sv
module mdm_engine
  import mdm_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  mdm_cmd_t           cmd,
  input  logic [DIV_W-1:0]   div,
  input  logic               mdio_in,
  output logic               busy,
  output logic               done,
  output logic               ack,
  output logic [MDATA_W-1:0] rd_data,
  output logic               mdc,
  output logic               mdo,
  output logic               oe
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = PRE_LEN + 14;
  localparam int ACK_POS   = TA_POS + 1;
  localparam int DAT_POS   = TA_POS + 2;
  localparam int LAST_POS  = FRAME_LEN - 1;

  logic [DIV_W-1:0]     cnt, cnt_n, dv, half;
  logic [DIV_W-1:0]     dv_st, half_st;
  logic [DIV_W:0]       sum_st;
  logic [IDX_W-1:0]     bidx;
  logic [FRAME_LEN-1:0] shreg, frame;
  logic                 rd_q, wrap, rise;

  // frame image, first bit on the wire at the MSB
  always_comb begin
    frame = {{PRE_LEN{1'b1}}, 2'b01,
             cmd.wr ? 2'b01 : 2'b10,
             cmd.phy_ad, cmd.reg_ad,
             cmd.wr ? 2'b10 : 2'b11,
             cmd.wr ? cmd.data : {MDATA_W{1'b1}}};
  end

  // divider: zero is clamped to one so MDC always has a high and a low phase
  always_comb begin
    dv_st   = (div == '0) ? DIV_W'(1) : div;
    sum_st  = {1'b0, dv_st} + 1'b1;
    half_st = sum_st[DIV_W:1];
    wrap    = (cnt == dv);
    cnt_n   = wrap ? '0 : cnt + 1'b1;
    rise    = (cnt_n == half);
  end

  assign mdo = shreg[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ack     <= 1'b0;
      rd_data <= '0;
      mdc     <= 1'b0;
      oe      <= 1'b0;
      cnt     <= '0;
      dv      <= DIV_W'(1);
      half    <= DIV_W'(1);
      bidx    <= '0;
      shreg   <= '0;
      rd_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt   <= '0;
          dv    <= dv_st;
          half  <= half_st;
          bidx  <= '0;
          shreg <= frame;
          oe    <= 1'b1;
          mdc   <= 1'b0;
          rd_q  <= !cmd.wr;
          ack   <= 1'b0;
        end
      end else begin
        cnt <= cnt_n;
        mdc <= (cnt_n >= half);
        // sample on the MDC rising edge
        if (rise && rd_q) begin
          if (bidx == IDX_W'(ACK_POS))
            ack <= !mdio_in;
          if (bidx >= IDX_W'(DAT_POS))
            rd_data <= {rd_data[MDATA_W-2:0], mdio_in};
        end
        // advance on the MDC falling edge
        if (wrap) begin
          if (bidx == IDX_W'(LAST_POS)) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            oe    <= 1'b0;
            shreg <= '0;
          end else begin
            bidx  <= bidx + 1'b1;
            shreg <= shreg << 1;
            oe    <= !(rd_q && (bidx >= IDX_W'(TA_POS - 1)));
          end
        end
      end
    end
  end

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !oe)); // R3

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_q && (bidx >= IDX_W'(TA_POS))) |-> !oe); // R6

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R4
endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
  import mdm_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               reg_rvalid,
  output logic               ctl_en,
  output logic [DIV_W-1:0]   ctl_div,
  output logic               man_sel,
  output logic               man_mdc,
  output logic               man_oe,
  output logic               man_out,
  output mdm_cmd_t           cmd,
  output logic               start,
  input  logic               eng_busy,
  input  logic               eng_done,
  input  logic               eng_ack,
  input  logic [MDATA_W-1:0] eng_rdata,
  input  logic               pin_in
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_ACCESS = ADDR_W'(ADR_ACCESS);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(ADR_MODE);
  localparam logic [ADDR_W-1:0] A_MANUAL = ADDR_W'(ADR_MANUAL);

  logic             go, ack_q, wr_en;
  logic [REG_W-1:0] rd_mux;
  logic             unused_wd;

  assign unused_wd = ^reg_wdata[29:26];
  assign wr_en     = reg_valid && reg_write;
  assign start     = go && ctl_en && !man_sel && !eng_busy && !eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en  <= 1'b0;
      ctl_div <= '0;
      man_sel <= 1'b0;
      man_mdc <= 1'b0;
      man_oe  <= 1'b0;
      man_out <= 1'b0;
      cmd     <= '0;
      go      <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (reg_addr)
          A_CTRL: begin
            ctl_en  <= reg_wdata[B_EN];
            ctl_div <= reg_wdata[DIV_W-1:0];
          end
          A_ACCESS: begin
            if (!go) begin
              go         <= reg_wdata[B_GO];
              cmd.wr     <= reg_wdata[B_WR];
              cmd.reg_ad <= reg_wdata[B_RAD_LO +: REG_AD_W];
              cmd.phy_ad <= reg_wdata[B_PAD_LO +: PHY_AD_W];
              cmd.data   <= reg_wdata[MDATA_W-1:0];
              ack_q      <= 1'b0;
            end
          end
          A_MODE:  man_sel <= reg_wdata[31];
          default: begin
            man_mdc <= reg_wdata[2];
            man_oe  <= reg_wdata[1];
            man_out <= reg_wdata[0];
          end
        endcase
      end
      if (eng_done) begin
        go <= 1'b0;
        if (!cmd.wr) begin
          ack_q    <= eng_ack;
          cmd.data <= eng_rdata;
        end else begin
          ack_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[B_IDLE]      = !eng_busy;
        rd_mux[B_EN]        = ctl_en;
        rd_mux[DIV_W-1:0]   = ctl_div;
      end
      A_ACCESS: begin
        rd_mux[B_GO]                  = go;
        rd_mux[B_WR]                  = cmd.wr;
        rd_mux[B_ACK]                 = ack_q;
        rd_mux[B_RAD_LO +: REG_AD_W]  = cmd.reg_ad;
        rd_mux[B_PAD_LO +: PHY_AD_W]  = cmd.phy_ad;
        rd_mux[MDATA_W-1:0]           = cmd.data;
      end
      A_MODE:   rd_mux[31] = man_sel;
      A_MANUAL: rd_mux[2:0] = {man_mdc, man_oe, pin_in};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_valid && !reg_write;
      if (reg_valid && !reg_write)
        reg_rdata <= rd_mux;
    end
  end

  AST_GO_HELD: assert property (@(posedge clk) disable iff (rst)
    (go && !eng_done) |=> go); // R4

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (go && !eng_done) |=> ($stable(cmd.phy_ad) && $stable(cmd.reg_ad) && $stable(cmd.wr))); // R7
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdm_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic               ctl_en, man_sel, man_mdc, man_oe, man_out;
  logic [DIV_W-1:0]   ctl_div;
  mdm_cmd_t           cmd;
  logic               start, eng_busy, eng_done, eng_ack;
  logic [MDATA_W-1:0] eng_rdata;
  logic               eng_mdc, eng_mdo, eng_oe;

  assign reg_ready = 1'b1;

  mdm_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .ctl_en(ctl_en), .ctl_div(ctl_div), .man_sel(man_sel),
    .man_mdc(man_mdc), .man_oe(man_oe), .man_out(man_out),
    .cmd(cmd), .start(start),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_ack(eng_ack),
    .eng_rdata(eng_rdata), .pin_in(mdio_i)
  );

  mdm_engine #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) engine_i (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .div(ctl_div),
    .mdio_in(mdio_i), .busy(eng_busy), .done(eng_done), .ack(eng_ack),
    .rd_data(eng_rdata), .mdc(eng_mdc), .mdo(eng_mdo), .oe(eng_oe)
  );

  // registered pin stage, manual override selected here
  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_o   <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (man_sel) begin
      mdc_o   <= man_mdc;
      mdio_o  <= man_out;
      mdio_oe <= man_oe;
    end else begin
      mdc_o   <= eng_mdc;
      mdio_o  <= eng_mdo;
      mdio_oe <= eng_oe;
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> ($past(ctl_en) && !$past(man_sel))); // R8

  AST_MANUAL_PINS: assert property (@(posedge clk) disable iff (rst)
    (man_sel && $past(man_sel)) |-> (mdc_o == $past(man_mdc) && mdio_oe == $past(man_oe))); // R9
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready, reg_rvalid;
  logic [31:0] reg_rdata;
  logic        mdc_o, mdio_o, mdio_oe, mdio_i;

  int n_chk = 0, n_fail = 0;

  // behavioural PHY and pin observers
  logic        man_drive = 1'b0, man_pin = 1'b1, phy_pin = 1'b1;
  logic [15:0] phy_val = 16'h0000;
  localparam logic [4:0] PHY_HERE = 5'd9;
  logic [63:0] cap = '0, oecap = '0;
  int          phy_idx = 0;
  logic        rd_active = 1'b0;
  int          cyc = 0, last_rise = 0, last_per = 0, n_rise = 0;
  logic        mdc_d = 1'b0;

  assign mdio_i = man_drive ? man_pin : phy_pin;

  always #4 clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc_o) begin
    cap     <= {cap[62:0], mdio_o};
    oecap   <= {oecap[62:0], mdio_oe};
    phy_idx <= (phy_idx + 1) % 64;
  end

  always @(negedge mdc_o) begin
    if (phy_idx == 46)
      rd_active = ({cap[11], cap[10]} == 2'b10) && (cap[9:5] == PHY_HERE);
    if (phy_idx == 47)
      phy_pin = rd_active ? 1'b0 : 1'b1;
    else if (phy_idx >= 48)
      phy_pin = rd_active ? phy_val[63 - phy_idx] : 1'b1;
    else
      phy_pin = 1'b1;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdc_o && !mdc_d) begin
      last_per  = cyc - last_rise;
      last_rise = cyc;
      n_rise    = n_rise + 1;
    end
    mdc_d = mdc_o;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic rv);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d  = reg_rdata;
    rv = reg_rvalid;
  endtask

  function automatic logic [31:0] acc_word(input bit w, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    return {1'b1, w, 4'b0000, ra, phy, d};
  endfunction

  function automatic logic [63:0] wr_frame(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, d};
  endfunction

  task automatic wait_idle(input string req);
    logic [31:0] d;
    logic rv;
    int n;
    n = 0;
    do begin
      rd(2'd1, d, rv);
      n++;
    end while (d[31] && n < 3000);
    check(!d[31], req, {32'd0, d}, 64'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic rv;
    rd(2'd0, d, rv);
    check(d == 32'h8000_0000, "R1 ctrl reset", {32'd0, d}, 64'h8000_0000);
    rd(2'd1, d, rv);
    check(d == 32'h0, "R1 access reset", {32'd0, d}, 64'h0);
    check(!mdc_o && !mdio_oe, "R1 pins reset", {62'd0, mdc_o, mdio_oe}, 64'd0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    logic rv;
    wr(2'd0, 32'h4000_0003);
    rd(2'd0, d, rv);
    check(d == 32'hC000_0003, "R2 ctrl readback", {32'd0, d}, 64'hC000_0003);
    check(rv && reg_ready, "R10 read valid", {62'd0, rv, reg_ready}, 64'd3);
    @(negedge clk);
    check(!reg_rvalid, "R10 valid one cycle", {63'd0, reg_rvalid}, 64'd0);
  endtask

  task automatic t_write();
    logic [31:0] d;
    logic rv;
    wr(2'd1, acc_word(1'b1, 5'd9, 5'h12, 16'hA5C3));
    rd(2'd1, d, rv);
    check(d[31], "R4 go held", {63'd0, d[31]}, 64'd1);
    rd(2'd0, d, rv);
    check(!d[31], "R4 idle low while busy", {63'd0, d[31]}, 64'd0);
    wait_idle("R4 go clears");
    check(cap == wr_frame(5'd9, 5'h12, 16'hA5C3), "R5 write frame", cap, wr_frame(5'd9, 5'h12, 16'hA5C3));
    check(oecap == 64'hFFFF_FFFF_FFFF_FFFF, "R5 write drives all bits", oecap, 64'hFFFF_FFFF_FFFF_FFFF);
    check(last_per == 4, "R3 period div3", 64'(last_per), 64'd4);
  endtask

  task automatic t_read_present();
    logic [31:0] d;
    logic rv;
    phy_val = 16'h3C96;
    wr(2'd1, acc_word(1'b0, PHY_HERE, 5'h05, 16'h0000));
    wait_idle("R4 read completes");
    rd(2'd1, d, rv);
    check(d[29] && d[15:0] == 16'h3C96, "R6 read ack data", {32'd0, d}, 64'h2000_3C96);
    check(oecap[17:0] == 18'd0 && &oecap[63:18], "R6 release from turnaround", oecap, 64'hFFFF_FFFF_FFFC_0000);
    check(cap[63:18] == {32'hFFFF_FFFF, 2'b01, 2'b10, PHY_HERE, 5'h05}, "R5 read header",
          {18'd0, cap[63:18]}, {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, PHY_HERE, 5'h05});
  endtask

  task automatic t_read_absent();
    logic [31:0] d;
    logic rv;
    wr(2'd1, acc_word(1'b0, 5'd3, 5'h01, 16'h0000));
    wait_idle("R4 read completes");
    rd(2'd1, d, rv);
    check(!d[29], "R6 no ack", {63'd0, d[29]}, 64'd0);
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    logic rv;
    wr(2'd1, acc_word(1'b1, 5'd9, 5'h01, 16'h1111));
    wr(2'd1, acc_word(1'b1, 5'd4, 5'h02, 16'h2222));
    rd(2'd1, d, rv);
    check(d[25:16] == {5'h01, 5'd9} && d[15:0] == 16'h1111, "R7 fields kept",
          {32'd0, d}, {32'd0, acc_word(1'b1, 5'd9, 5'h01, 16'h1111)});
    wait_idle("R7 completes");
    check(cap == wr_frame(5'd9, 5'h01, 16'h1111), "R7 first frame sent", cap, wr_frame(5'd9, 5'h01, 16'h1111));
    repeat (40) @(negedge clk);
    rd(2'd1, d, rv);
    check(!d[31], "R7 no second frame", {63'd0, d[31]}, 64'd0);
  endtask

  task automatic t_divs();
    wr(2'd0, 32'h4000_0004);
    wr(2'd1, acc_word(1'b1, 5'd1, 5'h03, 16'h00FF));
    wait_idle("R3 div4 done");
    check(last_per == 5, "R3 period div4", 64'(last_per), 64'd5);
    wr(2'd0, 32'h4000_0000);
    wr(2'd1, acc_word(1'b1, 5'd1, 5'h03, 16'hFF00));
    wait_idle("R3 div0 done");
    check(last_per == 2, "R3 period div0 clamp", 64'(last_per), 64'd2);
    check(cap == wr_frame(5'd1, 5'h03, 16'hFF00), "R5 frame at div0", cap, wr_frame(5'd1, 5'h03, 16'hFF00));
  endtask

  task automatic t_enable();
    logic [31:0] d;
    logic rv;
    int r0;
    wr(2'd0, 32'h4000_0003);
    wr(2'd1, acc_word(1'b1, 5'd7, 5'h0A, 16'hBEEF));
    repeat (60) @(negedge clk);
    wr(2'd0, 32'h0000_0003);
    rd(2'd0, d, rv);
    check(!d[31], "R8 frame continues", {63'd0, d[31]}, 64'd0);
    wait_idle("R8 frame finishes");
    rd(2'd0, d, rv);
    check(d == 32'h8000_0003, "R8 idle after disable", {32'd0, d}, 64'h8000_0003);
    check(cap == wr_frame(5'd7, 5'h0A, 16'hBEEF), "R8 full frame", cap, wr_frame(5'd7, 5'h0A, 16'hBEEF));
    r0 = n_rise;
    wr(2'd1, acc_word(1'b1, 5'd2, 5'h0B, 16'h1234));
    repeat (100) @(negedge clk);
    rd(2'd1, d, rv);
    check(d[31], "R8 pending while disabled", {63'd0, d[31]}, 64'd1);
    check(n_rise == r0, "R8 MDC quiet", 64'(n_rise), 64'(r0));
    wr(2'd0, 32'h4000_0003);
    wait_idle("R8 runs once enabled");
    check(cap == wr_frame(5'd2, 5'h0B, 16'h1234), "R8 pending frame", cap, wr_frame(5'd2, 5'h0B, 16'h1234));
  endtask

  task automatic t_manual();
    logic [31:0] d;
    logic rv;
    wr(2'd2, 32'h8000_0000);
    rd(2'd2, d, rv);
    check(d == 32'h8000_0000, "R9 mode readback", {32'd0, d}, 64'h8000_0000);
    wr(2'd3, 32'h7);
    repeat (2) @(negedge clk);
    check({mdc_o, mdio_oe, mdio_o} == 3'b111, "R9 pins 111", {61'd0, mdc_o, mdio_oe, mdio_o}, 64'd7);
    wr(2'd3, 32'h2);
    repeat (2) @(negedge clk);
    check({mdc_o, mdio_oe, mdio_o} == 3'b010, "R9 pins 010", {61'd0, mdc_o, mdio_oe, mdio_o}, 64'd2);
    man_drive = 1'b1;
    man_pin   = 1'b0;
    rd(2'd3, d, rv);
    check(d[0] == 1'b0, "R9 pin level low", {63'd0, d[0]}, 64'd0);
    man_pin = 1'b1;
    rd(2'd3, d, rv);
    check(d[0] == 1'b1, "R9 pin level high", {63'd0, d[0]}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_write();
    t_read_present();
    t_read_absent();
    t_ignore();
    t_divs();
    t_enable();
    t_manual();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule